// File: doc/BRIEF.md
# Page Access Rights and Protection-Key Checker

This block sits at the end of a page-table walk and decides whether the memory access that triggered the walk may proceed. The walker hands it the permission bits gathered across all levels (user, writable, no-execute), the final leaf entry and a status telling whether the walk ended normally, on a missing entry or on a reserved-bit violation. The block combines these with the access kind, the current privilege and the paging control flags. Before anything else it checks that the virtual address is canonical.

One cycle after each request it returns a registered result. The result carries a fault flag, a general-protection flag, a page-fault error code, the set of rights (read, write, execute) that a translation cache may record, and the updated leaf entry with its accessed and dirty bits. A separate flag tells the walker whether that entry must be written back.

Protection keys are held in two key registers, one for user pages and one for supervisor pages. Each register holds two bits per key. The key number comes from a four-bit field in the leaf entry.

Top module: `pg_access_checker`

## Requirements
- R1: When long mode is on, the virtual address must be canonical: bits 63..47 all equal, or bits 63..56 all equal when 5-level paging is on. A non-canonical address gives fault=1, gp=1, error code 0, rights 0 and no write-back. This check takes priority over every other check. Outside long mode the address is never checked.
- R2: A walk status of 01 (entry not present) gives a page fault with error bit 0 (P) clear. A walk status of 10 (reserved bit set) gives a page fault with both bit 0 (P) and bit 3 (RSVD) set.
- R3: A user access (req_user=1) to a page whose accumulated user bit is 0 is a protection fault: error bit 0 is set and the fault flag is raised.
- R4: Write rights are granted when the accumulated writable bit is 1, or when the access is supervisor and cr_wp is 0. A write access without write rights is a protection fault.
- R5: Execute rights are granted only when the accumulated no-execute bit is 0 and either the access is user or the page is not a user page while cr_smep is set. A fetch without execute rights is a protection fault.
- R6: The key is leaf bits 62..59. It selects register bit 2k (access-disable) and bit 2k+1 (write-disable). The user key register applies to user pages when cr_pke=1. The supervisor key register applies to supervisor pages when cr_pks=1. Outside long mode no key applies.
- R7: Access-disable removes read and write rights. Otherwise write-disable removes write rights when the access is user or cr_wp=1. A read or write refused by a key is a protection fault with error bit 5 (PK) set. Fetch is never refused by a key.
- R8: For every page fault, error bit 1 is set for a write (access 01) and bit 2 for a user access. Bit 4 is set for a fetch (access 10) only when cr_nxe and cr_pae are both set, or cr_smep is set.
- R9: On an allowed access, the returned leaf has bit 5 (accessed) set. A write also sets bit 6 (dirty). The write-back flag is raised exactly when this changes the entry. Write rights are left out of the returned rights when the returned leaf's dirty bit is 0. Rights encoding: bit 0 read, bit 1 write, bit 2 execute.
- R10: Each request (req_valid=1) produces rsp_valid=1 exactly one cycle later, and rsp_valid=0 otherwise. A faulting result has rights 0, no write-back, and returns the leaf unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address being translated |
| req_access | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | Access made at user privilege |
| walk_status | input | 2 | 00 completed, 01 not present, 10 reserved bit |
| walk_user | input | 1 | Accumulated user bit |
| walk_rw | input | 1 | Accumulated writable bit |
| walk_nx | input | 1 | Accumulated no-execute bit |
| leaf_entry | input | 64 | Final entry reached by the walk |
| cr_wp | input | 1 | Supervisor write protection enable |
| cr_smep | input | 1 | Supervisor fetch from user pages is blocked |
| cr_pke | input | 1 | Keys enabled for user pages |
| cr_pks | input | 1 | Keys enabled for supervisor pages |
| cr_nxe | input | 1 | No-execute enable |
| cr_pae | input | 1 | Extended paging format in use |
| cr_long | input | 1 | Long mode active |
| cr_la57 | input | 1 | Five-level paging active |
| ukey_reg | input | 32 | User key register |
| skey_reg | input | 32 | Supervisor key register |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Access refused |
| rsp_gp | output | 1 | Refusal is a general-protection fault |
| rsp_err | output | 16 | Page-fault error code |
| rsp_rights | output | 3 | Granted rights {x,w,r} |
| rsp_leaf_wr | output | 1 | Leaf entry must be written back |
| rsp_leaf | output | 64 | Leaf entry with accessed/dirty applied |

## Verification
The block holds no state apart from its output register. A fault in the decision logic therefore shows at the ports on the very next cycle, in the fault flag, the error code or the rights. A wrong key-bit index or a wrong register choice shows only when the selected key bits differ from their neighbours. For that reason the random key registers are dense, and the directed cases set a single key bit. A wrong canonical boundary shows only near bit 47 or bit 56, so those addresses are driven directly. Errors in accessed/dirty handling show in the returned leaf and in the write-back flag of the same result.

// File: rtl/pg_access_pkg.sv
package pg_access_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } access_kind_t;

    typedef enum logic [1:0] {
        WALK_DONE  = 2'b00,
        WALK_ABSENT = 2'b01,
        WALK_RSVD  = 2'b10
    } walk_stat_t;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    // error code bit positions
    localparam int ERR_P    = 0;
    localparam int ERR_WR   = 1;
    localparam int ERR_USR  = 2;
    localparam int ERR_RSVD = 3;
    localparam int ERR_ID   = 4;
    localparam int ERR_PK   = 5;

    // leaf entry fields
    localparam int LEAF_ACC   = 5;
    localparam int LEAF_DIRTY = 6;
    localparam int LEAF_KEY_LO = 59;

    function automatic logic access_needs(input rights_t rt, input logic [1:0] kind);
        case (kind)
            ACC_WRITE: access_needs = rt.w;
            ACC_FETCH: access_needs = rt.x;
            default:   access_needs = rt.r;
        endcase
    endfunction

    function automatic logic all_same(input logic [63:0] v, input int lo);
        logic ones, zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo) begin
                ones  = ones & v[i];
                zeros = zeros & ~v[i];
            end
        end
        all_same = ones | zeros;
    endfunction

endpackage

// File: rtl/pg_canon_check.sv
module pg_canon_check
    import pg_access_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int LO4_BIT   = 47,
    parameter int LO5_BIT   = 56
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            long_mode,
    input  logic            five_level,
    output logic            canon_ok
);
    localparam int PAD = 64 - VA_W;

    logic [63:0] wide;
    logic        ok4, ok5;

    generate
        if (PAD > 0) begin : g_pad
            assign wide = {{PAD{vaddr[VA_W-1]}}, vaddr};
        end else begin : g_nopad
            assign wide = vaddr;
        end
    endgenerate

    always_comb begin
        ok4 = all_same(wide, LO4_BIT);
        ok5 = all_same(wide, LO5_BIT);
        canon_ok = !long_mode || (five_level ? ok5 : ok4);
    end
endmodule

// File: rtl/pg_base_rights.sv
module pg_base_rights
    import pg_access_pkg::*;
(
    input  logic    is_user,
    input  logic    page_user,
    input  logic    page_rw,
    input  logic    page_nx,
    input  logic    wp,
    input  logic    smep,
    output logic    priv_fault,
    output rights_t base
);
    always_comb begin
        priv_fault = is_user && !page_user;
        base.r = 1'b1;
        base.w = page_rw || (!is_user && !wp);
        base.x = !page_nx && (is_user || !(smep && page_user));
    end
endmodule

// File: rtl/pg_key_domain.sv
module pg_key_domain
    import pg_access_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int KEYS  = 1 << KEY_W,
    localparam int REG_W = 2 * KEYS
) (
    input  logic [KEY_W-1:0] key,
    input  logic             long_mode,
    input  logic             page_user,
    input  logic             is_user,
    input  logic             wp,
    input  logic             pke,
    input  logic             pks,
    input  logic [REG_W-1:0] ukey,
    input  logic [REG_W-1:0] skey,
    output rights_t          key_mask
);
    logic [REG_W-1:0] sel;
    logic [1:0]       pair;

    always_comb begin
        if (!long_mode)
            sel = '0;
        else if (page_user)
            sel = pke ? ukey : '0;
        else
            sel = pks ? skey : '0;
        pair = sel[2*key +: 2];
        key_mask.x = 1'b1;
        key_mask.r = !pair[0];
        key_mask.w = !pair[0] && !(pair[1] && (is_user || wp));
    end
endmodule

// File: rtl/pg_access_checker.sv
module pg_access_checker
    import pg_access_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PTE_W = 64,
    parameter int KEY_W = 4,
    parameter int ERR_W = 16,
    localparam int PKR_W = 2 * (1 << KEY_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_access,
    input  logic             req_user,
    input  logic [1:0]       walk_status,
    input  logic             walk_user,
    input  logic             walk_rw,
    input  logic             walk_nx,
    input  logic [PTE_W-1:0] leaf_entry,
    input  logic             cr_wp,
    input  logic             cr_smep,
    input  logic             cr_pke,
    input  logic             cr_pks,
    input  logic             cr_nxe,
    input  logic             cr_pae,
    input  logic             cr_long,
    input  logic             cr_la57,
    input  logic [PKR_W-1:0] ukey_reg,
    input  logic [PKR_W-1:0] skey_reg,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic             rsp_gp,
    output logic [ERR_W-1:0] rsp_err,
    output logic [2:0]       rsp_rights,
    output logic             rsp_leaf_wr,
    output logic [PTE_W-1:0] rsp_leaf
);
    logic             canon_ok;
    logic             priv_fault;
    rights_t          base, kmask, granted, final_rights;
    logic             key_deny, rights_deny, prot_fault, walk_fault, any_fault;
    logic             is_write, is_fetch;
    logic [ERR_W-1:0] err_c;
    logic [PTE_W-1:0] leaf_c;

    pg_canon_check #(.VA_W(VA_W)) u_canon (
        .vaddr(req_vaddr), .long_mode(cr_long), .five_level(cr_la57),
        .canon_ok(canon_ok)
    );

    pg_base_rights u_base (
        .is_user(req_user), .page_user(walk_user), .page_rw(walk_rw),
        .page_nx(walk_nx), .wp(cr_wp), .smep(cr_smep),
        .priv_fault(priv_fault), .base(base)
    );

    pg_key_domain #(.KEY_W(KEY_W)) u_key (
        .key(leaf_entry[LEAF_KEY_LO +: KEY_W]), .long_mode(cr_long),
        .page_user(walk_user), .is_user(req_user), .wp(cr_wp),
        .pke(cr_pke), .pks(cr_pks), .ukey(ukey_reg), .skey(skey_reg),
        .key_mask(kmask)
    );

    always_comb begin
        is_write    = (req_access == ACC_WRITE);
        is_fetch    = (req_access == ACC_FETCH);
        walk_fault  = (walk_status != WALK_DONE);
        granted     = base & kmask;
        key_deny    = !priv_fault && !access_needs(kmask, req_access);
        rights_deny = !access_needs(granted, req_access);
        prot_fault  = priv_fault || key_deny || rights_deny;
        any_fault   = walk_fault || prot_fault;

        err_c = '0;
        err_c[ERR_RSVD] = (walk_status == WALK_RSVD);
        err_c[ERR_P]    = (walk_status == WALK_RSVD) || (!walk_fault && prot_fault);
        err_c[ERR_PK]   = !walk_fault && key_deny;
        err_c[ERR_WR]   = is_write;
        err_c[ERR_USR]  = req_user;
        err_c[ERR_ID]   = is_fetch && ((cr_nxe && cr_pae) || cr_smep);

        leaf_c = leaf_entry;
        if (!any_fault) begin
            leaf_c[LEAF_ACC] = 1'b1;
            if (is_write)
                leaf_c[LEAF_DIRTY] = 1'b1;
        end
        final_rights = granted;
        if (!leaf_c[LEAF_DIRTY])
            final_rights.w = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_gp      <= 1'b0;
            rsp_err     <= '0;
            rsp_rights  <= '0;
            rsp_leaf_wr <= 1'b0;
            rsp_leaf    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (!canon_ok) begin
                    rsp_fault   <= 1'b1;
                    rsp_gp      <= 1'b1;
                    rsp_err     <= '0;
                    rsp_rights  <= '0;
                    rsp_leaf_wr <= 1'b0;
                    rsp_leaf    <= leaf_entry;
                end else begin
                    rsp_fault   <= any_fault;
                    rsp_gp      <= 1'b0;
                    rsp_err     <= any_fault ? err_c : '0;
                    rsp_rights  <= any_fault ? 3'b000 : final_rights;
                    rsp_leaf_wr <= !any_fault && (leaf_c != leaf_entry);
                    rsp_leaf    <= leaf_c;
                end
            end
        end
    end

    // R10: strobe follows request by one cycle
    a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R10: faulting result grants nothing and requests no write-back
    a_r10_fault_empty: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_rights == 3'b000 && !rsp_leaf_wr);
    // R1: general-protection result has error code zero
    a_r1_gp_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_gp |-> rsp_fault && rsp_err == '0);
    // R3: user access to supervisor page faults when the walk completed
    a_r3_user_sup: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_user && !walk_user && walk_status == WALK_DONE
        |=> rsp_fault);
    // R9: write rights only with a dirty leaf
    a_r9_wr_dirty: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_rights[1] |-> rsp_leaf[LEAF_DIRTY]);
    // R7: key error always comes with a protection error
    a_r7_pk_with_p: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_err[ERR_PK] |-> rsp_err[ERR_P]);
endmodule

// File: tb/pg_access_checker_tb.sv
module pg_access_checker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_access;
    logic        req_user;
    logic [1:0]  walk_status;
    logic        walk_user, walk_rw, walk_nx;
    logic [63:0] leaf_entry;
    logic        cr_wp, cr_smep, cr_pke, cr_pks, cr_nxe, cr_pae, cr_long, cr_la57;
    logic [31:0] ukey_reg, skey_reg;
    logic        rsp_valid, rsp_fault, rsp_gp, rsp_leaf_wr;
    logic [15:0] rsp_err;
    logic [2:0]  rsp_rights;
    logic [63:0] rsp_leaf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pg_access_checker u_dut (.*);

    // expected result vector: {fault, gp, err[15:0], rights[2:0], leaf_wr, leaf[63:0]}
    function automatic logic [85:0] model();
        logic fault, gp, wflt, pf, kd, canon;
        logic [15:0] err;
        logic r, w, x, kr, kw;
        logic [31:0] kreg;
        logic [3:0]  k;
        logic [63:0] lf;
        logic        need;
        canon = 1'b1;
        if (cr_long) begin
            if (cr_la57)
                canon = (req_vaddr[63:56] == 8'h00) || (req_vaddr[63:56] == 8'hFF);
            else
                canon = (req_vaddr[63:47] == 17'h0) || (req_vaddr[63:47] == 17'h1FFFF);
        end
        if (!canon) return {1'b1, 1'b1, 16'h0, 3'b0, 1'b0, leaf_entry};
        r = 1'b1;
        w = walk_rw || (!req_user && !cr_wp);
        x = !walk_nx && (req_user || !(cr_smep && walk_user));
        kreg = !cr_long ? 32'h0 : (walk_user ? (cr_pke ? ukey_reg : 32'h0)
                                             : (cr_pks ? skey_reg : 32'h0));
        k = leaf_entry[62:59];
        kr = !kreg[2*k];
        kw = kr && !(kreg[2*k+1] && (req_user || cr_wp));
        need = (req_access == 2'b01) ? (w && kw) : (req_access == 2'b10) ? x : (r && kr);
        kd = (req_access == 2'b01) ? !kw : (req_access == 2'b10) ? 1'b0 : !kr;
        pf = (req_user && !walk_user);
        if (pf) kd = 1'b0;
        wflt = (walk_status != 2'b00);
        fault = wflt || pf || kd || !need;
        err = 16'h0;
        if (fault) begin
            err[3] = (walk_status == 2'b10);
            err[0] = (walk_status == 2'b10) || !wflt;
            err[5] = !wflt && kd;
            err[1] = (req_access == 2'b01);
            err[2] = req_user;
            err[4] = (req_access == 2'b10) && ((cr_nxe && cr_pae) || cr_smep);
        end
        gp = 1'b0;
        lf = leaf_entry;
        if (fault) return {1'b1, gp, err, 3'b0, 1'b0, lf};
        lf[5] = 1'b1;
        if (req_access == 2'b01) lf[6] = 1'b1;
        w = w && kw && lf[6];
        r = r && kr;
        return {1'b0, gp, err, x, w, r, (lf != leaf_entry), lf};
    endfunction

    task automatic drive_defaults();
        req_valid = 1'b0; req_vaddr = 64'h0; req_access = 2'b00; req_user = 1'b0;
        walk_status = 2'b00; walk_user = 1'b1; walk_rw = 1'b1; walk_nx = 1'b0;
        leaf_entry = 64'h0; cr_wp = 1'b0; cr_smep = 1'b0; cr_pke = 1'b0; cr_pks = 1'b0;
        cr_nxe = 1'b0; cr_pae = 1'b0; cr_long = 1'b0; cr_la57 = 1'b0;
        ukey_reg = 32'h0; skey_reg = 32'h0;
    endtask

    task automatic issue(input string tag);
        logic [85:0] exp, act;
        req_valid = 1'b1;
        exp = model();
        @(negedge clk);
        req_valid = 1'b0;
        act = {rsp_fault, rsp_gp, rsp_err, rsp_rights, rsp_leaf_wr, rsp_leaf};
        checks++;
        if (!rsp_valid || act !== exp) begin
            errors++;
            $display("FAIL %s: actual valid=%b %h expected valid=1 %h", tag, rsp_valid, act, exp);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        drive_defaults();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_err !== 16'h0) begin
            errors++;
            $display("FAIL R10 reset: actual valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
        end

        // R1 canonical boundaries
        cr_long = 1'b1; req_vaddr = 64'h0000_8000_0000_0000; issue("R1 noncanon 47");
        cr_la57 = 1'b1; issue("R1 same addr fine with 5-level");
        req_vaddr = 64'h0100_0000_0000_0000; walk_status = 2'b10; issue("R1 noncanon 56 beats walk fault");
        cr_long = 1'b0; cr_la57 = 1'b0; issue("R1 no check outside long mode");
        walk_status = 2'b00; req_vaddr = 64'h0;
        // R2 walk faults
        walk_status = 2'b01; req_access = 2'b01; issue("R2 not present write");
        walk_status = 2'b10; req_user = 1'b1; issue("R2 reserved user");
        walk_status = 2'b00;
        // R3
        walk_user = 1'b0; req_access = 2'b00; issue("R3 user to supervisor page");
        // R4 supervisor write override
        req_user = 1'b0; walk_rw = 1'b0; req_access = 2'b01; issue("R4 wp clear allows write");
        cr_wp = 1'b1; issue("R4 wp set blocks write");
        // R5 smep fetch
        walk_user = 1'b1; req_access = 2'b10; cr_smep = 1'b1; issue("R5 smep blocks fetch, R8 id bit");
        cr_smep = 1'b0; cr_nxe = 1'b1; cr_pae = 1'b1; walk_nx = 1'b1; issue("R5 nx fetch, R8 id bit");
        walk_nx = 1'b0;
        // R6/R7 keys
        cr_long = 1'b1; cr_pke = 1'b1; walk_rw = 1'b1; req_user = 1'b1;
        leaf_entry = 64'h0; leaf_entry[62:59] = 4'd5; ukey_reg = 32'h1 << 10;
        req_access = 2'b00; issue("R7 access-disable key 5 read");
        ukey_reg = 32'h1 << 11; req_access = 2'b01; issue("R7 write-disable key 5");
        ukey_reg = 32'h1 << 12; issue("R6 neighbour key bit ignored");
        skey_reg = 32'h1 << 10; ukey_reg = 32'h0; req_access = 2'b00; issue("R6 supervisor reg unused for user page");
        walk_user = 1'b0; req_user = 1'b0; cr_pks = 1'b1; issue("R6 supervisor key access-disable");
        cr_long = 1'b0; issue("R6 keys off outside long mode");
        cr_long = 1'b1; skey_reg = 32'h1 << 11; cr_wp = 1'b0; req_access = 2'b01; issue("R7 write-disable skipped when wp clear");
        req_access = 2'b10; skey_reg = 32'h1 << 10; issue("R7 fetch not refused by key");
        // R9 dirty/accessed
        skey_reg = 32'h0; req_access = 2'b00; leaf_entry = 64'h0; issue("R9 read sets accessed, withholds write");
        req_access = 2'b01; issue("R9 write sets dirty and accessed");
        leaf_entry = 64'h60; req_access = 2'b00; issue("R9 already set no write-back");

        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic [47:0] a;
            a = {$urandom, $urandom};
            req_vaddr = {{16{a[47]}}, a};
            if ($urandom_range(0, 9) == 0) req_vaddr[60] = ~req_vaddr[60];
            if ($urandom_range(0, 9) == 0) req_vaddr = {{7{a[47]}}, a[47:0], 9'h0};
            req_access = 2'($urandom_range(0, 2));
            req_user = 1'($urandom);
            walk_status = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 2)) : 2'b00;
            walk_user = 1'($urandom); walk_rw = 1'($urandom); walk_nx = 1'($urandom);
            leaf_entry = {$urandom, $urandom};
            {cr_wp, cr_smep, cr_pke, cr_pks, cr_nxe, cr_pae, cr_long, cr_la57} = 8'($urandom);
            ukey_reg = $urandom & $urandom; skey_reg = $urandom & $urandom;
            issue("R10 random mix");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule